// File: doc/BRIEF.md
# Line Status Change Interrupt Controller

This block watches six level-type line status flags and two single-cycle buffer error events, the elastic buffer overflow and underflow. When a cause is enabled and changes state, it latches a pending bit and pulls an active-low, open-drain style interrupt line to the host. A status flag counts as changed on either edge, so both the arrival and the clearing of a condition are reported. The flags arrive asynchronously. Each one passes through a two-flop synchronizer and is then compared with its previous synchronized value.

The host reaches the block over a small parallel register bus with combinational read data. It can read the synchronized flag levels, the pending causes and the current mask. The host has a single clear/mask register. Writing a one to a bit acknowledges that cause and masks it. Writing a zero to a bit re-enables it. While a cause is masked its events are discarded and not stored, so re-enabling a cause never raises a stale interrupt.

Top module: `status_irq_ctrl`

## Requirements
- R1: After reset, every pending bit and every mask bit is zero, and `irqN_o` is 1 (released).
- R2: A rising change on line flag i (bit i, 0..5) sets pending bit i no later than the third rising clock edge after the input changes.
- R3: A falling change on line flag i also sets pending bit i, with the same latency as R2.
- R4: A high `ovfPulse_i` sampled at a clock edge sets pending bit 6, and a high `unfPulse_i` sets pending bit 7, at that same edge.
- R5: `irqN_o` is 0 while any pending bit is set whose mask bit is zero. Otherwise it is 1.
- R6: A bus write to address 2 loads the mask with the write data. At the same edge it clears every pending bit whose data bit is one.
- R7: An event on a masked cause never sets its pending bit. After the cause is unmasked, no interrupt appears for events that happened while it was masked.
- R8: If an event and a mask write fall on the same edge, the newly written mask value decides whether the event is latched.
- R9: A read returns a value that depends on the address. Address 0 gives the synchronized flags in bits 5:0 with bits 7:6 zero. Address 1 gives the pending bits. Address 2 gives the mask. Address 3 gives zero.
- R10: Bus writes to addresses 0, 1 and 3 change neither the mask nor the pending bits.
- R11: Pending causes accumulate. They are cleared only by a mask write, and `irqN_o` stays 0 until every unmasked pending cause has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineFlags_i | input | 6 | Asynchronous status flags (bit order: signal loss, alarm indication, loopback detect, pattern detect, driver fail A, driver fail B) |
| ovfPulse_i | input | 1 | Elastic buffer overflow, one-cycle synchronous pulse |
| unfPulse_i | input | 1 | Elastic buffer underflow, one-cycle synchronous pulse |
| busSel_i | input | 1 | Register access strobe |
| busWe_i | input | 1 | 1 = write, 0 = read |
| busAddr_i | input | 2 | Register address |
| busWdata_i | input | 8 | Write data |
| busRdata_o | output | 8 | Read data, valid in the same cycle as a read access |
| irqN_o | output | 1 | Interrupt, 0 = pulled low, 1 = released |

## Verification
A cause event and a host write to the clear/mask register can land on the same clock edge. The next value of the pending register then depends on both the clear and the new mask. The bench provokes this by raising the overflow and underflow pulses during the cycle of a mask write. That write unmasks the overflow bit and masks the underflow bit. The pending register read afterwards must show overflow latched and underflow dropped, and the mask must show the written value.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int FLAG_W  = 6;
  parameter int CAUSE_W = FLAG_W + 2;
  parameter int DATA_W  = CAUSE_W;
  parameter int ADDR_W  = 2;
  parameter int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PEND  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;

  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    maskWr;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[STAGES-2:0], din};
  end

  assign dout = chainQ[STAGES-1];
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe.maskWr = busSel && busWe && (busAddr == ADDR_MASK);
    strobe.rdSel  = SEL_NONE;
    if (busSel && !busWe) begin
      unique case (busAddr)
        ADDR_FLAGS: strobe.rdSel = SEL_FLAGS;
        ADDR_PEND:  strobe.rdSel = SEL_PEND;
        ADDR_MASK:  strobe.rdSel = SEL_MASK;
        default:    strobe.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [FLAG_W-1:0]  lineFlags,
  input  logic               ovfPulse,
  input  logic               unfPulse,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [CAUSE_W-1:0] pendingQ,
  output logic [CAUSE_W-1:0] maskQ,
  output logic               irqN
);
  localparam int PAD_W = DATA_W - FLAG_W;

  logic [FLAG_W-1:0]  flagSync;
  logic [FLAG_W-1:0]  flagPrevQ;
  logic [FLAG_W-1:0]  flagEdge;
  logic [CAUSE_W-1:0] causeEvent;
  logic [CAUSE_W-1:0] maskNext;
  logic [CAUSE_W-1:0] clrBits;
  logic [CAUSE_W-1:0] pendNext;

  for (genvar g = 0; g < FLAG_W; g++) begin : gSync
    intc_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .rstN (rstN),
      .din  (lineFlags[g]),
      .dout (flagSync[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagPrevQ <= '0;
    else       flagPrevQ <= flagSync;
  end

  assign flagEdge   = flagSync ^ flagPrevQ;
  assign causeEvent = {unfPulse, ovfPulse, flagEdge};

  always_comb begin
    maskNext = maskQ;
    clrBits  = '0;
    if (strobe.maskWr) begin
      maskNext = wrData[CAUSE_W-1:0];
      clrBits  = wrData[CAUSE_W-1:0];
    end
    pendNext = (pendingQ & ~clrBits) | (causeEvent & ~maskNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= '0;
      maskQ    <= '0;
    end else begin
      pendingQ <= pendNext;
      maskQ    <= maskNext;
    end
  end

  assign irqN = ~|(pendingQ & ~maskQ);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_FLAGS: rdData = {{PAD_W{1'b0}}, flagSync};
      SEL_PEND:  rdData = pendingQ;
      SEL_MASK:  rdData = maskQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] lineFlags_i,
  input  logic              ovfPulse_i,
  input  logic              unfPulse_i,
  input  logic              busSel_i,
  input  logic              busWe_i,
  input  logic [ADDR_W-1:0] busAddr_i,
  input  logic [DATA_W-1:0] busWdata_i,
  output logic [DATA_W-1:0] busRdata_o,
  output logic              irqN_o
);
  ctrlStrobe_t        strobe;
  logic [CAUSE_W-1:0] pendingW;
  logic [CAUSE_W-1:0] maskW;

  intc_ctrl uCtrl (
    .busSel  (busSel_i),
    .busWe   (busWe_i),
    .busAddr (busAddr_i),
    .strobe  (strobe)
  );

  intc_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .lineFlags (lineFlags_i),
    .ovfPulse  (ovfPulse_i),
    .unfPulse  (unfPulse_i),
    .strobe    (strobe),
    .wrData    (busWdata_i),
    .rdData    (busRdata_o),
    .pendingQ  (pendingW),
    .maskQ     (maskW),
    .irqN      (irqN_o)
  );
endmodule

// File: rtl/status_irq_chk.sv
module status_irq_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ovfPulse,
  input logic               unfPulse,
  input logic               busSel,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [CAUSE_W-1:0] pending,
  input logic [CAUSE_W-1:0] mask,
  input logic               irqN
);
  logic maskWrite;
  assign maskWrite = busSel && busWe && (busAddr == ADDR_MASK);

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pending == '0) && (mask == '0) && irqN);

  // R5
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (pending != '0));

  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> irqN);

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> (mask == $past(busWdata)) && ((pending & $past(busWdata)) == '0));

  // R7
  masked_no_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending & mask) == '0);

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(mask));

  // R11
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> ((pending & $past(pending)) == $past(pending)));

  // R4
  ovf_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && (maskWrite ? !busWdata[FLAG_W] : !mask[FLAG_W])) |=> pending[FLAG_W]);

  // R4
  unf_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unfPulse && (maskWrite ? !busWdata[FLAG_W+1] : !mask[FLAG_W+1])) |=> pending[FLAG_W+1]);
endmodule

bind status_irq_ctrl status_irq_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ovfPulse (ovfPulse_i),
  .unfPulse (unfPulse_i),
  .busSel   (busSel_i),
  .busWe    (busWe_i),
  .busAddr  (busAddr_i),
  .busWdata (busWdata_i),
  .pending  (pendingW),
  .mask     (maskW),
  .irqN     (irqN_o)
);

// File: tb/tb_status_irq_ctrl.sv
`timescale 1ns/1ps
module tb_status_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] lineFlags = '0;
  logic       ovfPulse = 1'b0;
  logic       unfPulse = 1'b0;
  logic       busSel = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqN;

  int checks = 0;
  int fails  = 0;
  logic chkReq = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  status_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .lineFlags_i(lineFlags),
    .ovfPulse_i(ovfPulse), .unfPulse_i(unfPulse),
    .busSel_i(busSel), .busWe_i(busWe), .busAddr_i(busAddr),
    .busWdata_i(busWdata), .busRdata_o(busRdata), .irqN_o(irqN)
  );

  // monitor: pops one expected item per read cycle and compares at the falling edge
  always @(negedge clk) begin
    if (chkReq && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (busRdata !== e.data) begin
        fails++;
        $display("FAIL %s data: actual %h expected %h", e.tag, busRdata, e.data);
      end
      checks++;
      if (irqN !== e.irq) begin
        fails++;
        $display("FAIL %s irqN: actual %b expected %b", e.tag, irqN, e.irq);
      end
    end
  end

  task automatic readReg(input logic [1:0] a, input logic [7:0] d, input logic irqExp, input string tag);
    expItem_t e;
    @(posedge clk); #1;
    e.data = d; e.irq = irqExp; e.tag = tag;
    expQ.push_back(e);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    chkReq = 1'b1;
    @(posedge clk); #1;
    busSel = 1'b0; chkReq = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d, input logic ovf, input logic unf);
    @(posedge clk); #1;
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    ovfPulse = ovf; unfPulse = unf;
    @(posedge clk); #1;
    busSel = 1'b0; busWe = 1'b0; ovfPulse = 1'b0; unfPulse = 1'b0;
  endtask

  task automatic setFlags(input logic [5:0] f);
    @(posedge clk); #1;
    lineFlags = f;
    repeat (3) @(posedge clk);
  endtask

  task automatic pulse(input logic ovf, input logic unf);
    @(posedge clk); #1;
    ovfPulse = ovf; unfPulse = unf;
    @(posedge clk); #1;
    ovfPulse = 1'b0; unfPulse = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    readReg(2'd1, 8'h00, 1'b1, "R1 pending");
    readReg(2'd2, 8'h00, 1'b1, "R1 mask");
    // R2 rising change on flag 0
    setFlags(6'h01);
    readReg(2'd0, 8'h01, 1'b0, "R9 flags");
    readReg(2'd1, 8'h01, 1'b0, "R2 pending");
    // R6 clear and mask
    writeReg(2'd2, 8'h01, 1'b0, 1'b0);
    readReg(2'd1, 8'h00, 1'b1, "R6 pending");
    readReg(2'd2, 8'h01, 1'b1, "R6 mask");
    // R7 masked fall is dropped, no stale irq on unmask
    setFlags(6'h00);
    readReg(2'd1, 8'h00, 1'b1, "R7 masked");
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    readReg(2'd1, 8'h00, 1'b1, "R7 unmasked");
    // R3 falling change on flag 2
    setFlags(6'h04);
    writeReg(2'd2, 8'h04, 1'b0, 1'b0);
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    setFlags(6'h00);
    readReg(2'd1, 8'h04, 1'b0, "R3 pending");
    writeReg(2'd2, 8'h04, 1'b0, 1'b0);
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    // R4 buffer events
    pulse(1'b1, 1'b0);
    readReg(2'd1, 8'h40, 1'b0, "R4 overflow");
    writeReg(2'd2, 8'h40, 1'b0, 1'b0);
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    pulse(1'b0, 1'b1);
    readReg(2'd1, 8'h80, 1'b0, "R4 underflow");
    // R11 accumulation, irq held until all cleared
    setFlags(6'h20);
    readReg(2'd1, 8'hA0, 1'b0, "R11 accumulate");
    writeReg(2'd2, 8'h80, 1'b0, 1'b0);
    readReg(2'd1, 8'h20, 1'b0, "R11 partial clear");
    writeReg(2'd2, 8'h20, 1'b0, 1'b0);
    readReg(2'd1, 8'h00, 1'b1, "R11 all cleared");
    readReg(2'd2, 8'h20, 1'b1, "R6 mask reload");
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    // R10 writes elsewhere ignored
    pulse(1'b1, 1'b0);
    writeReg(2'd1, 8'hFF, 1'b0, 1'b0);
    writeReg(2'd0, 8'hFF, 1'b0, 1'b0);
    writeReg(2'd3, 8'hFF, 1'b0, 1'b0);
    readReg(2'd1, 8'h40, 1'b0, "R10 pending kept");
    readReg(2'd2, 8'h00, 1'b0, "R10 mask kept");
    writeReg(2'd2, 8'h40, 1'b0, 1'b0);
    // R8 events coincide with mask write (mask was 0x40, new mask 0x80)
    writeReg(2'd2, 8'h80, 1'b1, 1'b1);
    readReg(2'd1, 8'h40, 1'b0, "R8 pending");
    readReg(2'd2, 8'h80, 1'b0, "R8 mask");
    writeReg(2'd2, 8'h40, 1'b0, 1'b0);
    writeReg(2'd2, 8'h00, 1'b0, 1'b0);
    // R9 remaining addresses, R5 multiple flags
    readReg(2'd3, 8'h00, 1'b1, "R9 addr3");
    setFlags(6'h3F);
    readReg(2'd0, 8'h3F, 1'b0, "R9 flags all");
    readReg(2'd1, 8'h1F, 1'b0, "R5 pending flags");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule